// File: doc/BRIEF.md
# Stack-Pointer Load Expander

This block is purely combinational. It reads one 16-bit compressed instruction and detects whether it is one of the loads addressed relative to the stack pointer. If it is, the block emits the equivalent 32-bit base-ISA load. The load can be word, doubleword, quadword or single-precision floating-point. The emitted load always uses register x2 as its base and carries an unsigned, size-scaled immediate.

The same block also recognises two illegal cases and raises a separate illegal flag for them. The first is an integer stack load whose destination is x0. The second is a stack-load encoding that the configured machine does not provide. A front end places the block after instruction fetch. It uses the hit flag to choose the expanded word and sends the illegal flag to its exception logic.

Two parameters set which encodings are recognised: `XLEN` (32, 64 or 128) and `HAS_F` (whether single-precision floating point is present). Encodings outside this group of stack loads produce no hit and no illegal flag.

Top module: `stack_load_expander`

## Requirements
- R1: When `valid_i` is low, or `instr_i[1:0]` is not 2'b10, or `instr_i[15:13]` is none of 010, 011, 001, then `hit_o`, `illegal_o` and `expanded_o` are all zero. This also applies to 001 when XLEN is not 128: that encoding is outside this block's group.
- R2: For `instr_i[15:13]`=010 with a nonzero rd, the output is a word load with this layout:
  - immediate in [31:20], rs1=2 in [19:15], width 010 in [14:12], rd in [11:7], opcode 0000011 in [6:0].
  - The offset is taken from the instruction as: offset[5] at bit 12, offset[4:2] at bits [6:4], offset[7:6] at bits [3:2].
- R3: For funct3 011 with XLEN 64 or 128 and a nonzero rd, the output is a doubleword load with width 011 and opcode 0000011.
  - The offset is taken as: offset[5] at bit 12, offset[4:3] at bits [6:5], offset[8:6] at bits [4:2].
- R4: For funct3 001 with XLEN 128 and a nonzero rd, the output is a quadword load with width 010 and opcode 0001111.
  - The offset is taken as: offset[5] at bit 12, offset[4] at bit 6, offset[9:6] at bits [5:2].
- R5: For funct3 011 with XLEN 32 and `HAS_F` set, the output is a floating-point word load with width 010 and opcode 0000111. It uses the word offset layout of R2, and rd=0 is legal.
- R6: For funct3 011 with XLEN 32 and `HAS_F` clear, `illegal_o` is 1 while `hit_o` and `expanded_o` are zero.
- R7: An integer stack load (R2, R3, R4) whose rd field is 0 raises `illegal_o`, and `hit_o` and `expanded_o` are zero.
- R8: The offset is zero-extended into the 12-bit immediate. Even the largest offsets (252, 504, 1008) leave bits [31:30] clear.
- R9: `hit_o` and `illegal_o` are never high together.
- R10: On a hit, `expanded_o[11:7]` equals `instr_i[11:7]` and `expanded_o[19:15]` equals 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Compressed instruction |
| valid_i | input | 1 | Instruction present |
| expanded_o | output | 32 | Expanded 32-bit load, zero when no hit |
| hit_o | output | 1 | A legal stack load was expanded |
| illegal_o | output | 1 | Illegal stack-load encoding |

## Verification
The bench builds four copies of the block that share the same inputs:
- XLEN 32 with F;
- XLEN 32 without F;
- XLEN 64;
- XLEN 128.

Every encoding of funct3 010, 011 and 001 therefore meets every legality outcome in the same cycle. This covers the floating-point reading, the reserved reading, the doubleword reading, the quadword reading and the out-of-group reading of the same bits. The sweep goes through all 64 offset-field values and all 32 rd values. The expected offset comes from searching the encoder for the bits that produce the field, so the bench never decodes the way the RTL does. Other quadrants, other funct3 values and an invalid input complete the no-hit cases.

// File: rtl/slx_pkg.sv
package slx_pkg;

  typedef enum logic [2:0] {
    LK_NONE,
    LK_WORD,
    LK_DWORD,
    LK_QWORD,
    LK_FWORD
  } ld_kind_e;

  localparam logic [1:0] QUAD_STACK = 2'b10;
  localparam logic [2:0] F3_QSP     = 3'b001;
  localparam logic [2:0] F3_WSP     = 3'b010;
  localparam logic [2:0] F3_DSP     = 3'b011;

  localparam logic [6:0] OPC_LOAD    = 7'b0000011;
  localparam logic [6:0] OPC_LOADFP  = 7'b0000111;
  localparam logic [6:0] OPC_MISCMEM = 7'b0001111;
  localparam logic [2:0] W_WORD      = 3'b010;
  localparam logic [2:0] W_DWORD     = 3'b011;
  localparam logic [4:0] SP_REG      = 5'd2;

  // The offset field is {instr[12], instr[6:2]}: fld[5]=bit12, fld[4]=bit6 ... fld[0]=bit2
  function automatic logic [11:0] word_offset(logic [5:0] fld);
    return {4'b0, fld[1:0], fld[5], fld[4:2], 2'b00};
  endfunction

  function automatic logic [11:0] dword_offset(logic [5:0] fld);
    return {3'b0, fld[2:0], fld[5], fld[4:3], 3'b000};
  endfunction

  function automatic logic [11:0] qword_offset(logic [5:0] fld);
    return {2'b0, fld[3:0], fld[5], fld[4], 4'b0000};
  endfunction

  function automatic logic [31:0] make_itype(logic [11:0] imm, logic [4:0] rs1,
                                             logic [2:0] width, logic [4:0] rd,
                                             logic [6:0] opc);
    return {imm, rs1, width, rd, opc};
  endfunction

endpackage

// File: rtl/slx_classify.sv
module slx_classify
  import slx_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter bit HAS_F = 1'b1
) (
  input  logic       valid_i,
  input  logic [1:0] quad_i,
  input  logic [2:0] f3_i,
  output ld_kind_e   kind_o,
  output logic       reserved_o
);
  localparam bit DWORD_OK = (XLEN >= 64);
  localparam bit QWORD_OK = (XLEN == 128);
  localparam bit FWORD_OK = (XLEN == 32) && HAS_F;
  localparam bit RESV_011 = (XLEN == 32) && !HAS_F;

  ld_kind_e kind_011;
  ld_kind_e kind_001;
  logic     in_quad;

  generate
    if (FWORD_OK) begin : g_f011
      assign kind_011 = LK_FWORD;
    end else if (DWORD_OK) begin : g_d011
      assign kind_011 = LK_DWORD;
    end else begin : g_n011
      assign kind_011 = LK_NONE;
    end
    if (QWORD_OK) begin : g_q001
      assign kind_001 = LK_QWORD;
    end else begin : g_n001
      assign kind_001 = LK_NONE;
    end
  endgenerate

  assign in_quad = valid_i && (quad_i == QUAD_STACK);

  always_comb begin
    kind_o = LK_NONE;
    if (in_quad) begin
      case (f3_i)
        F3_WSP:  kind_o = LK_WORD;
        F3_DSP:  kind_o = kind_011;
        F3_QSP:  kind_o = kind_001;
        default: kind_o = LK_NONE;
      endcase
    end
  end

  assign reserved_o = in_quad && (f3_i == F3_DSP) && RESV_011;

endmodule

// File: rtl/slx_offset.sv
module slx_offset
  import slx_pkg::*;
(
  input  ld_kind_e    kind_i,
  input  logic [5:0]  field_i,
  output logic [11:0] imm_o
);
  always_comb begin
    case (kind_i)
      LK_WORD, LK_FWORD: imm_o = word_offset(field_i);
      LK_DWORD:          imm_o = dword_offset(field_i);
      LK_QWORD:          imm_o = qword_offset(field_i);
      default:           imm_o = '0;
    endcase
  end
endmodule

// File: rtl/slx_assemble.sv
module slx_assemble
  import slx_pkg::*;
(
  input  ld_kind_e    kind_i,
  input  logic [11:0] imm_i,
  input  logic [4:0]  rd_i,
  output logic [31:0] word_o
);
  always_comb begin
    case (kind_i)
      LK_WORD:  word_o = make_itype(imm_i, SP_REG, W_WORD,  rd_i, OPC_LOAD);
      LK_DWORD: word_o = make_itype(imm_i, SP_REG, W_DWORD, rd_i, OPC_LOAD);
      LK_QWORD: word_o = make_itype(imm_i, SP_REG, W_WORD,  rd_i, OPC_MISCMEM);
      LK_FWORD: word_o = make_itype(imm_i, SP_REG, W_WORD,  rd_i, OPC_LOADFP);
      default:  word_o = '0;
    endcase
  end
endmodule

// File: rtl/stack_load_expander.sv
module stack_load_expander
  import slx_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter bit HAS_F = 1'b1
) (
  input  logic [15:0] instr_i,
  input  logic        valid_i,
  output logic [31:0] expanded_o,
  output logic        hit_o,
  output logic        illegal_o
);
  ld_kind_e    raw_kind;
  ld_kind_e    eff_kind;
  logic        reserved_enc;
  logic        dest_zero;
  logic        int_kind;
  logic        drop_x0;
  logic [11:0] imm;
  logic [5:0]  off_field;

  slx_classify #(.XLEN(XLEN), .HAS_F(HAS_F)) u_classify (
    .valid_i    (valid_i),
    .quad_i     (instr_i[1:0]),
    .f3_i       (instr_i[15:13]),
    .kind_o     (raw_kind),
    .reserved_o (reserved_enc)
  );

  assign dest_zero = (instr_i[11:7] == 5'd0);
  assign int_kind  = (raw_kind == LK_WORD) || (raw_kind == LK_DWORD) || (raw_kind == LK_QWORD);
  assign drop_x0   = int_kind && dest_zero;
  assign eff_kind  = drop_x0 ? LK_NONE : raw_kind;
  assign off_field = {instr_i[12], instr_i[6:2]};

  slx_offset u_offset (
    .kind_i  (eff_kind),
    .field_i (off_field),
    .imm_o   (imm)
  );

  slx_assemble u_assemble (
    .kind_i (eff_kind),
    .imm_i  (imm),
    .rd_i   (instr_i[11:7]),
    .word_o (expanded_o)
  );

  assign hit_o     = (eff_kind != LK_NONE);
  assign illegal_o = drop_x0 || reserved_enc;

  always_comb begin
    if (!$isunknown({instr_i, valid_i, expanded_o, hit_o, illegal_o})) begin
      assert_hit_ill_excl_R9: assert (!(hit_o && illegal_o))
        else $error("hit and illegal both high");
      assert_miss_zero_R1: assert (hit_o || expanded_o == 32'd0)
        else $error("nonzero output without hit");
      assert_x0_blocked_R7: assert (!drop_x0 || (illegal_o && !hit_o))
        else $error("x0 destination not blocked");
      assert_fields_R10: assert (!hit_o || (expanded_o[11:7] == instr_i[11:7]
                                            && expanded_o[19:15] == SP_REG))
        else $error("rd or base register wrong");
      assert_zero_ext_R8: assert (!hit_o || expanded_o[31:30] == 2'b00)
        else $error("immediate upper bits set");
      assert_fp_cfg_R5: assert (!(hit_o && expanded_o[6:0] == OPC_LOADFP)
                                || (XLEN == 32 && HAS_F))
        else $error("floating-point load in wrong configuration");
      assert_quad_cfg_R4: assert (!(hit_o && expanded_o[6:0] == OPC_MISCMEM) || XLEN == 128)
        else $error("quadword load without XLEN 128");
      assert_invalid_quiet_R1: assert (valid_i || (!hit_o && !illegal_o))
        else $error("activity with valid low");
    end
  end

endmodule

// File: tb/stack_load_expander_test.sv
module stack_load_expander_test;

  typedef struct packed {
    logic [31:0] word;
    logic        hit;
    logic        ill;
    logic [3:0]  req;
  } one_t;
  typedef one_t [3:0] quad_t;

  function automatic int cfg_xlen(int g);
    case (g)
      0, 1:    return 32;
      2:       return 64;
      default: return 128;
    endcase
  endfunction

  function automatic bit cfg_f(int g);
    return (g != 1);
  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = '0;
  logic        valid = 1'b0;
  logic [31:0] res_word [4];
  logic        res_hit  [4];
  logic        res_ill  [4];

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  quad_t sb[$];
  quad_t cur;

  always #5 clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : uut
    stack_load_expander #(.XLEN(cfg_xlen(g)), .HAS_F(cfg_f(g))) dut (
      .instr_i    (instr),
      .valid_i    (valid),
      .expanded_o (res_word[g]),
      .hit_o      (res_hit[g]),
      .illegal_o  (res_ill[g])
    );
  end

  // Encoder view: which {bit12, bits6:2} carries a given offset
  function automatic logic [5:0] enc_field(int scale, int off);
    logic [9:0] o;
    o = 10'(off);
    case (scale)
      4:       return {o[5], o[4:2], o[7:6]};
      8:       return {o[5], o[4:3], o[8:6]};
      default: return {o[5], o[4],   o[9:6]};
    endcase
  endfunction

  function automatic logic [11:0] find_off(int scale, logic [5:0] fld);
    for (int k = 0; k < 64; k++)
      if (enc_field(scale, k * scale) == fld) return 12'(k * scale);
    return 12'hfff;
  endfunction

  function automatic one_t model(int x, bit f, logic [15:0] c, logic v);
    one_t r;
    logic [5:0]  fld;
    logic [4:0]  rd;
    logic [11:0] off;
    int          scale;
    r = '{word: 32'd0, hit: 1'b0, ill: 1'b0, req: 4'd1};
    fld = {c[12], c[6:2]};
    rd  = c[11:7];
    scale = 0;
    if (v && c[1:0] == 2'b10) begin
      case (c[15:13])
        3'b010: begin                                   // R2 word
          if (rd == 0) begin r.ill = 1'b1; r.req = 4'd7; end
          else begin
            scale = 4; off = find_off(4, fld);
            r.word = {off, 5'd2, 3'b010, rd, 7'b0000011}; r.hit = 1'b1; r.req = 4'd2;
          end
        end
        3'b011: begin
          if (x == 32) begin
            if (f) begin                                // R5 float word, rd=0 allowed
              scale = 4; off = find_off(4, fld);
              r.word = {off, 5'd2, 3'b010, rd, 7'b0000111}; r.hit = 1'b1; r.req = 4'd5;
            end else begin r.ill = 1'b1; r.req = 4'd6; end  // R6
          end else if (rd == 0) begin r.ill = 1'b1; r.req = 4'd7; end
          else begin                                    // R3 doubleword
            scale = 8; off = find_off(8, fld);
            r.word = {off, 5'd2, 3'b011, rd, 7'b0000011}; r.hit = 1'b1; r.req = 4'd3;
          end
        end
        3'b001: begin
          if (x == 128) begin
            if (rd == 0) begin r.ill = 1'b1; r.req = 4'd7; end
            else begin                                  // R4 quadword
              scale = 16; off = find_off(16, fld);
              r.word = {off, 5'd2, 3'b010, rd, 7'b0001111}; r.hit = 1'b1; r.req = 4'd4;
            end
          end else r.req = 4'd4;
        end
        default: r.req = 4'd1;
      endcase
    end
    if (r.hit && scale != 0 && int'(r.word[31:20]) >= 32 * scale) r.req = 4'd8;  // R8
    else if (r.hit && rd == 5'd31) r.req = 4'd10;                                // R10
    return r;
  endfunction

  task automatic send(logic [15:0] c, logic v);
    quad_t e;
    @(posedge clk);
    instr <= c;
    valid <= v;
    for (int g = 0; g < 4; g++) e[g] = model(cfg_xlen(g), cfg_f(g), c, v);
    sb.push_back(e);
  endtask

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      for (int g = 0; g < 4; g++) begin
        checks++;
        if (res_word[g] !== cur[g].word || res_hit[g] !== cur[g].hit ||
            res_ill[g] !== cur[g].ill) begin
          errors++;
          $display("FAIL R%0d cfg%0d instr=%h: got word=%h hit=%b ill=%b, expected word=%h hit=%b ill=%b",
                   cur[g].req, g, instr, res_word[g], res_hit[g], res_ill[g],
                   cur[g].word, cur[g].hit, cur[g].ill);
        end
        checks++;
        if (res_hit[g] === 1'b1 && res_ill[g] === 1'b1) begin
          errors++;
          $display("FAIL R9 cfg%0d instr=%h: got hit=1 ill=1, expected at most one high", g, instr);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst <= 1'b0;
    // R1: reset state and invalid input
    send(16'h0000, 1'b0);
    send({3'b010, 1'b1, 5'd5, 5'h1f, 2'b10}, 1'b0);
    // R1: other quadrants and unhandled funct3 values
    for (int q = 0; q < 4; q++)
      if (q != 2) send({3'b010, 1'b0, 5'd9, 5'h0a, 2'(q)}, 1'b1);
    for (int f3 = 0; f3 < 8; f3++)
      if (f3 != 1 && f3 != 2 && f3 != 3) send({3'(f3), 1'b1, 5'd7, 5'h15, 2'b10}, 1'b1);
    // Full sweep: R2, R3, R4, R5, R6, R7, R8, R10 across the four configurations
    for (int s = 0; s < 3; s++) begin
      logic [2:0] f3s;
      f3s = (s == 0) ? 3'b010 : ((s == 1) ? 3'b011 : 3'b001);
      for (int rd = 0; rd < 32; rd++)
        for (int fld = 0; fld < 64; fld++)
          send({f3s, fld[5], rd[4:0], fld[4:0], 2'b10}, 1'b1);
    end
    @(posedge clk);
    valid <= 1'b0;
    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule